// File: doc/BRIEF.md
# Fault-Coverage Test Vector Selector

This block picks a small set of test vectors that still reaches the highest fault coverage a binary detection matrix allows. Each row of the matrix is one fault and each column is one of `NUM_VEC` test vectors. Bit `v` of a row is 1 exactly when vector `v` detects that fault, and vector index `v` is the binary input value applied to the test program. Rows are written one at a time while the block is idle. A start pulse then runs an iterative set-cover selection over the loaded rows. The chosen vector indices stream out in selection order under a valid/ready handshake. Each index comes with the running number of faults covered so far. A single-cycle done strobe closes the run and carries how many vectors were chosen.

The number of vectors that detect a fault is its order. Orders are counted once per run, before selection starts. Faults of order zero cannot be covered by any vector, so they are left out, and the loop always ends. Each iteration scores every vector against a mask of uncovered faults. The mode picks how that mask is formed. Greedy scores against all uncovered faults. Lowest-order-first uses the single rarest uncovered fault. Hybrid uses all uncovered faults that share the lowest order. In every mode, the vector with the highest score wins, and a tie goes to the lowest index.

Top module: `tvs_selector`

## Requirements
- R1: After reset, `sel_valid_o` and `done_o` are low, and no index is offered until a run is started.
- R2: While idle, each `row_valid_i` pulse stores `row_data_i` as the next fault row, starting from fault 0. Rows offered after `NUM_FAULT` rows are already held are ignored. A run uses only the rows loaded since the previous start (or since reset), and a start resets the row count to zero for the next load.
- R3: A loaded row with no bit set (order zero) is never treated as uncovered and never adds to the covered count. If no loaded row has any bit set, the run ends with a done count of 0 and offers no index.
- R4: With `mode_i` = 0 (and also with 3), each iteration selects the vector that detects the most still-uncovered faults. A tie goes to the lowest vector index.
- R5: With `mode_i` = 1, each iteration takes the uncovered fault of lowest order, with ties going to the lowest fault index. It then selects the lowest-index vector that detects that fault.
- R6: With `mode_i` = 2, each iteration forms the set of uncovered faults whose order equals the lowest uncovered order. It then selects the vector that detects the most faults of that set. A tie goes to the lowest vector index.
- R7: After each selection, every fault detected by the chosen vector becomes covered. `sel_covered_o` is the cumulative number of distinct faults covered, including the current index. The chosen vector always covers at least one new fault.
- R8: The run ends once no coverable fault remains uncovered. `done_o` is then high for exactly one cycle after the last accepted index, and `done_count_o` equals the number of indices offered.
- R9: While `sel_valid_o` is high and `sel_ready_i` is low, `sel_valid_o`, `sel_index_o` and `sel_covered_o` hold their values.
- R10: The final covered count equals the number of loaded rows of nonzero order. Every vector that is the only detector of some loaded fault appears among the selected indices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy sampled at start: 0/3 greedy, 1 lowest-order-first, 2 hybrid |
| row_valid_i | input | 1 | Write `row_data_i` as the next fault row (idle only) |
| row_data_i | input | NUM_VEC | Detection bits of one fault, bit v for vector v |
| start_i | input | 1 | Begin a selection run over the loaded rows (idle only, wins over a row write) |
| sel_valid_o | output | 1 | A selected vector index is offered |
| sel_ready_i | input | 1 | Consumer accepts the offered index |
| sel_index_o | output | $clog2(NUM_VEC) | Selected vector index |
| sel_covered_o | output | $clog2(NUM_FAULT+1) | Faults covered so far, including this index |
| done_o | output | 1 | One-cycle strobe after the last index of a run |
| done_count_o | output | $clog2(NUM_VEC+1) | Number of vectors selected in the run |

## Verification
The assertions check four things on every cycle. The offered index and count stay stable under backpressure. Every applied choice covers at least one new fault. No fault of order zero is ever held as uncovered. The done strobe lasts a single cycle. Other properties depend on the whole matrix and only the bench's scenarios can show them. These include the exact index sequence each policy produces, including the tie-breaks. They also include dropping rows beyond capacity and the guarantee that sole detectors of first-order faults are chosen. The bench checks all of these over many sparse matrices in all four mode codes, using a small configuration.

// File: rtl/tvs_pkg.sv
package tvs_pkg;

  typedef enum logic [1:0] {
    MODE_GREEDY     = 2'd0,
    MODE_LOWEST     = 2'd1,
    MODE_HYBRID     = 2'd2,
    MODE_GREEDY_ALT = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ORDER = 3'd1,
    ST_CHECK = 3'd2,
    ST_SCAN  = 3'd3,
    ST_APPLY = 3'd4,
    ST_EMIT  = 3'd5
  } state_e;

endpackage

// File: rtl/tvs_popcount.sv
module tvs_popcount #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] count_o
);

  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++) begin
      count_o = count_o + CW'(bits_i[i]);
    end
  end

endmodule

// File: rtl/tvs_matrix_store.sv
module tvs_matrix_store #(
  parameter int NUM_VEC   = 16,
  parameter int NUM_FAULT = 32,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int FW = (NUM_FAULT > 1) ? $clog2(NUM_FAULT) : 1
) (
  input  logic                 clk,
  input  logic                 wr_en_i,
  input  logic [FW-1:0]        wr_row_i,
  input  logic [NUM_VEC-1:0]   wr_data_i,
  input  logic [FW-1:0]        rd_row_i,
  output logic [NUM_VEC-1:0]   rd_data_o,
  input  logic [VW-1:0]        col_i,
  output logic [NUM_FAULT-1:0] col_o
);

  logic [NUM_VEC-1:0] mem_q [NUM_FAULT];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem_q[wr_row_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_row_i];

  for (genvar j = 0; j < NUM_FAULT; j++) begin : g_col
    assign col_o[j] = mem_q[j][col_i];
  end

endmodule

// File: rtl/tvs_rarest.sv
module tvs_rarest
  import tvs_pkg::*;
#(
  parameter int NUM_FAULT = 32,
  parameter int OW        = 5
) (
  input  mode_e                        mode_i,
  input  logic [NUM_FAULT-1:0]         uncov_i,
  input  logic [NUM_FAULT-1:0][OW-1:0] order_i,
  output logic [NUM_FAULT-1:0]         mask_o
);

  localparam int FW = (NUM_FAULT > 1) ? $clog2(NUM_FAULT) : 1;

  logic          found;
  logic [OW-1:0] min_ord;
  logic [FW-1:0] first_idx;

  // lowest order among uncovered faults, first index on ties
  always_comb begin
    found     = 1'b0;
    min_ord   = '1;
    first_idx = '0;
    for (int j = 0; j < NUM_FAULT; j++) begin
      if (uncov_i[j] && (!found || (order_i[j] < min_ord))) begin
        found     = 1'b1;
        min_ord   = order_i[j];
        first_idx = FW'(j);
      end
    end
  end

  always_comb begin
    mask_o = '0;
    case (mode_i)
      MODE_LOWEST: begin
        if (found) mask_o[first_idx] = 1'b1;
      end
      MODE_HYBRID: begin
        for (int j = 0; j < NUM_FAULT; j++) begin
          mask_o[j] = uncov_i[j] && (order_i[j] == min_ord);
        end
      end
      default: mask_o = uncov_i;
    endcase
  end

endmodule

// File: rtl/tvs_selector.sv
module tvs_selector
  import tvs_pkg::*;
#(
  parameter int NUM_VEC   = 16,
  parameter int NUM_FAULT = 32,
  localparam int VW  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int FCW = $clog2(NUM_FAULT + 1),
  localparam int VCW = $clog2(NUM_VEC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               row_valid_i,
  input  logic [NUM_VEC-1:0] row_data_i,
  input  logic               start_i,
  output logic               sel_valid_o,
  input  logic               sel_ready_i,
  output logic [VW-1:0]      sel_index_o,
  output logic [FCW-1:0]     sel_covered_o,
  output logic               done_o,
  output logic [VCW-1:0]     done_count_o
);

  localparam int FW = (NUM_FAULT > 1) ? $clog2(NUM_FAULT) : 1;
  localparam int OW = $clog2(NUM_VEC + 1);

  state_e                        state_q, state_d;
  mode_e                         mode_q, mode_d;
  logic [FCW-1:0]                wr_ptr_q, wr_ptr_d;
  logic [FCW-1:0]                nrows_q, nrows_d;
  logic [FW-1:0]                 ord_idx_q, ord_idx_d;
  logic [NUM_FAULT-1:0][OW-1:0]  order_q, order_d;
  logic [NUM_FAULT-1:0]          uncov_q, uncov_d;
  logic [VW-1:0]                 scan_q, scan_d;
  logic [VW-1:0]                 best_idx_q, best_idx_d;
  logic [FCW-1:0]                best_cnt_q, best_cnt_d;
  logic [FCW-1:0]                cov_q, cov_d;
  logic [VCW-1:0]                nsel_q, nsel_d;
  logic                          done_q, done_d;

  logic                 mem_we;
  logic [NUM_VEC-1:0]   row_bits;
  logic [NUM_FAULT-1:0] col_bits;
  logic [VW-1:0]        col_sel;
  logic [OW-1:0]        row_ones;
  logic [NUM_FAULT-1:0] sel_mask;
  logic [NUM_FAULT-1:0] pc_in;
  logic [FCW-1:0]       pc_cnt;

  tvs_matrix_store #(.NUM_VEC(NUM_VEC), .NUM_FAULT(NUM_FAULT)) u_store (
    .clk       (clk),
    .wr_en_i   (mem_we),
    .wr_row_i  (wr_ptr_q[FW-1:0]),
    .wr_data_i (row_data_i),
    .rd_row_i  (ord_idx_q),
    .rd_data_o (row_bits),
    .col_i     (col_sel),
    .col_o     (col_bits)
  );

  tvs_popcount #(.W(NUM_VEC), .CW(OW)) u_row_pc (
    .bits_i  (row_bits),
    .count_o (row_ones)
  );

  tvs_rarest #(.NUM_FAULT(NUM_FAULT), .OW(OW)) u_rarest (
    .mode_i  (mode_q),
    .uncov_i (uncov_q),
    .order_i (order_q),
    .mask_o  (sel_mask)
  );

  // one column port: scanned vector while scoring, chosen vector while applying
  assign col_sel = (state_q == ST_APPLY) ? best_idx_q : scan_q;
  assign pc_in   = (state_q == ST_APPLY) ? (uncov_q & col_bits) : (sel_mask & col_bits);

  tvs_popcount #(.W(NUM_FAULT), .CW(FCW)) u_col_pc (
    .bits_i  (pc_in),
    .count_o (pc_cnt)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    wr_ptr_d   = wr_ptr_q;
    nrows_d    = nrows_q;
    ord_idx_d  = ord_idx_q;
    order_d    = order_q;
    uncov_d    = uncov_q;
    scan_d     = scan_q;
    best_idx_d = best_idx_q;
    best_cnt_d = best_cnt_q;
    cov_d      = cov_q;
    nsel_d     = nsel_q;
    done_d     = 1'b0;
    mem_we     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          mode_d    = mode_e'(mode_i);
          nrows_d   = wr_ptr_q;
          wr_ptr_d  = '0;
          ord_idx_d = '0;
          uncov_d   = '0;
          cov_d     = '0;
          nsel_d    = '0;
          state_d   = (wr_ptr_q == '0) ? ST_CHECK : ST_ORDER;
        end else if (row_valid_i && (wr_ptr_q < FCW'(NUM_FAULT))) begin
          mem_we   = 1'b1;
          wr_ptr_d = wr_ptr_q + FCW'(1);
        end
      end
      ST_ORDER: begin
        order_d[ord_idx_q] = row_ones;
        uncov_d[ord_idx_q] = (row_ones != '0);
        if (FCW'(ord_idx_q) == (nrows_q - FCW'(1))) begin
          state_d = ST_CHECK;
        end else begin
          ord_idx_d = ord_idx_q + FW'(1);
        end
      end
      ST_CHECK: begin
        if (uncov_q == '0) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          scan_d     = '0;
          best_idx_d = '0;
          best_cnt_d = '0;
          state_d    = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (pc_cnt > best_cnt_q) begin
          best_cnt_d = pc_cnt;
          best_idx_d = scan_q;
        end
        if (scan_q == VW'(NUM_VEC - 1)) begin
          state_d = ST_APPLY;
        end else begin
          scan_d = scan_q + VW'(1);
        end
      end
      ST_APPLY: begin
        uncov_d = uncov_q & ~col_bits;
        cov_d   = cov_q + pc_cnt;
        nsel_d  = nsel_q + VCW'(1);
        state_d = ST_EMIT;
      end
      ST_EMIT: begin
        if (sel_ready_i) state_d = ST_CHECK;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_GREEDY;
      wr_ptr_q   <= '0;
      nrows_q    <= '0;
      ord_idx_q  <= '0;
      order_q    <= '0;
      uncov_q    <= '0;
      scan_q     <= '0;
      best_idx_q <= '0;
      best_cnt_q <= '0;
      cov_q      <= '0;
      nsel_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_d;
      wr_ptr_q   <= wr_ptr_d;
      nrows_q    <= nrows_d;
      ord_idx_q  <= ord_idx_d;
      order_q    <= order_d;
      uncov_q    <= uncov_d;
      scan_q     <= scan_d;
      best_idx_q <= best_idx_d;
      best_cnt_q <= best_cnt_d;
      cov_q      <= cov_d;
      nsel_q     <= nsel_d;
      done_q     <= done_d;
    end
  end

  assign sel_valid_o   = (state_q == ST_EMIT);
  assign sel_index_o   = best_idx_q;
  assign sel_covered_o = cov_q;
  assign done_o        = done_q;
  assign done_count_o  = nsel_q;

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_o && !sel_ready_i) |=>
      (sel_valid_o && $stable(sel_index_o) && $stable(sel_covered_o)));

  // R7
  new_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_APPLY) |-> ((uncov_q & col_bits) != '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  for (genvar j = 0; j < NUM_FAULT; j++) begin : g_ord_chk
    // R3
    zero_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uncov_q[j] |-> (order_q[j] != '0));
  end

endmodule

// File: tb/tvs_selector_bench.sv
module tvs_selector_bench;

  localparam int NV  = 8;
  localparam int NF  = 12;
  localparam int VW  = $clog2(NV);
  localparam int FCW = $clog2(NF + 1);
  localparam int VCW = $clog2(NV + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic [1:0]     mode;
  logic           row_valid;
  logic [NV-1:0]  row_data;
  logic           start;
  logic           sel_valid;
  logic           sel_ready;
  logic [VW-1:0]  sel_index;
  logic [FCW-1:0] sel_covered;
  logic           done;
  logic [VCW-1:0] done_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [NV-1:0] mat [NF];
  int exp_idx [NF + 1];
  int exp_cov [NF + 1];
  int exp_n;
  int obs_idx [NF + 1];
  int obs_n;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  tvs_selector #(.NUM_VEC(NV), .NUM_FAULT(NF)) u_tvs_selector (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode),
    .row_valid_i   (row_valid),
    .row_data_i    (row_data),
    .start_i       (start),
    .sel_valid_o   (sel_valid),
    .sel_ready_i   (sel_ready),
    .sel_index_o   (sel_index),
    .sel_covered_o (sel_covered),
    .done_o        (done),
    .done_count_o  (done_count)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // expected selection computed from the policy definitions
  task automatic model_run(input int md, input int nrows);
    bit unc [NF];
    int ord [NF];
    int cov = 0;
    bit any;
    exp_n = 0;
    for (int j = 0; j < NF; j++) begin
      ord[j] = $countones(mat[j]);
      unc[j] = (j < nrows) && (ord[j] != 0);
    end
    forever begin
      bit msk [NF];
      int mn = NV + 1;
      int first = -1;
      int best = 0;
      int bestc = 0;
      any = 0;
      for (int j = 0; j < NF; j++) if (unc[j]) any = 1;
      if (!any) break;
      for (int j = 0; j < NF; j++)
        if (unc[j] && ord[j] < mn) begin mn = ord[j]; first = j; end
      for (int j = 0; j < NF; j++) begin
        if (md == 1)      msk[j] = (j == first);
        else if (md == 2) msk[j] = unc[j] && (ord[j] == mn);
        else              msk[j] = unc[j];
      end
      for (int v = 0; v < NV; v++) begin
        int s = 0;
        for (int j = 0; j < NF; j++) if (msk[j] && mat[j][v]) s++;
        if (s > bestc) begin bestc = s; best = v; end
      end
      for (int j = 0; j < NF; j++)
        if (unc[j] && mat[j][best]) begin unc[j] = 0; cov++; end
      exp_idx[exp_n] = best;
      exp_cov[exp_n] = cov;
      exp_n++;
    end
  endtask

  task automatic run_case(input int md, input int nrows, input bit extra);
    string rq;
    int wait_n;
    rq = (md == 1) ? "R5" : (md == 2) ? "R6" : "R4";
    for (int j = 0; j < nrows; j++) begin
      @(negedge clk);
      row_valid = 1'b1;
      row_data  = mat[j];
    end
    if (extra) begin
      @(negedge clk);
      row_valid = 1'b1;
      row_data  = '1;
    end
    @(negedge clk);
    row_valid = 1'b0;
    model_run(md, nrows);
    mode  = 2'(md);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    obs_n = 0;
    for (int k = 0; k < exp_n; k++) begin
      wait_n = 0;
      while (!sel_valid && !done && wait_n < 400) begin
        @(negedge clk);
        wait_n++;
      end
      check(sel_valid == 1'b1, "R8", "index offered before done", int'(sel_valid), 1);
      if (!sel_valid) break;
      for (int s = 0; s < (k % 3); s++) begin
        @(negedge clk);
        // R9 hold under backpressure
        check(sel_valid && sel_index == VW'(exp_idx[k]), "R9", "held index",
              int'(sel_index), exp_idx[k]);
      end
      check(sel_index == VW'(exp_idx[k]), extra ? "R2" : rq, "selected index",
            int'(sel_index), exp_idx[k]);
      check(sel_covered == FCW'(exp_cov[k]), "R7", "covered count",
            int'(sel_covered), exp_cov[k]);
      obs_idx[obs_n] = int'(sel_index);
      obs_n++;
      sel_ready = 1'b1;
      @(negedge clk);
      sel_ready = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 400) begin
      check(sel_valid == 1'b0, "R8", "no extra index", int'(sel_valid), 0);
      @(negedge clk);
      wait_n++;
    end
    check(done == 1'b1, "R8", "done strobe", int'(done), 1);
    check(done_count == VCW'(exp_n), (exp_n == 0) ? "R3" : "R8", "done count",
          int'(done_count), exp_n);
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", int'(done), 0);
    // R10: sole detectors of loaded faults must be selected, full coverage reached
    begin
      int coverable = 0;
      for (int j = 0; j < nrows; j++) begin
        if (mat[j] != '0) coverable++;
        if ($countones(mat[j]) == 1) begin
          bit seen = 0;
          int sole = 0;
          for (int v = 0; v < NV; v++) if (mat[j][v]) sole = v;
          for (int k = 0; k < obs_n; k++) if (obs_idx[k] == sole) seen = 1;
          check(seen, "R10", "sole detector selected", int'(seen), 1);
        end
      end
      if (obs_n > 0)
        check(exp_cov[exp_n-1] == coverable && obs_n == exp_n, "R10",
              "final coverage", obs_n, exp_n);
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    mode      = '0;
    row_valid = 1'b0;
    row_data  = '0;
    start     = 1'b0;
    sel_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(sel_valid == 1'b0, "R1", "valid after reset", int'(sel_valid), 0);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);

    // R3: nothing loaded, then only empty rows
    run_case(0, 0, 1'b0);
    for (int j = 0; j < NF; j++) mat[j] = '0;
    run_case(2, 5, 1'b0);

    // one detector per fault, wrapping over vectors
    for (int j = 0; j < NF; j++) mat[j] = NV'(1) << (j % NV);
    run_case(0, NF, 1'b0);
    run_case(1, NF, 1'b0);

    // R2: a row beyond capacity is dropped
    for (int j = 0; j < NF; j++) mat[j] = next_rand()[NV-1:0] & next_rand()[NV-1:0];
    run_case(1, NF, 1'b1);

    // sparse random matrices across all mode codes and row counts
    for (int t = 0; t < 10; t++) begin
      for (int j = 0; j < NF; j++) begin
        if (t % 2 == 0) mat[j] = next_rand()[NV-1:0] & next_rand()[NV-1:0];
        else            mat[j] = next_rand()[NV-1:0] & next_rand()[NV-1:0] & next_rand()[NV-1:0];
      end
      for (int md = 0; md < 4; md++) run_case(md, NF - (t % 4), 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule